// File: doc/BRIEF.md
# Deadline-Ordered Ready List with Blocked-Head Bypass

This block holds pending tasks for a heterogeneous scheduler. Each entry carries a task identifier, an absolute deadline and two unit masks. The direct mask names the execution units that can run the task at once. The reconfiguration mask names the units that can host the task only after they are reprogrammed. Entries stay sorted with the earliest deadline first, and the head of the list has the first claim on dispatch.

In every cycle the block offers one task to a downstream mapper. The offered task is the earliest-deadline entry that has a feasible placement, given the per-unit free flags and the busy flag of the reconfiguration controller. If the head cannot be placed, it is skipped but it keeps its place in the list, so a stalled head does not hold back tasks that could run on other units. The mapper also receives the mask of units that the offered task could use in that cycle.

The insert side is a push with no back-pressure: each `ins_valid` cycle is either stored or dropped. A drop happens when all entries are in use, and it is reported on the overflow flag. The dispatch side follows valid/ready rules. `dsp_valid` is derived in the same cycle from the stored list and the current unit flags, and an entry leaves the list only on a cycle where `dsp_valid` and `dsp_ready` are both high. `dsp_valid` does not wait for `dsp_ready`. While `dsp_ready` is low, the offer may change only when the unit flags change or when a new insert reorders the list.

Top module: `edf_ready_list`

## Requirements
- R1: After reset the list is empty, `dsp_valid` is low and `overflow` is low.
- R2: Entries are held sorted by unsigned deadline, smallest first. Among feasible entries, the one with the smallest deadline is offered on `dsp_id`/`dsp_deadline`.
- R3: Entries with equal deadlines are offered in the order in which they were inserted.
- R4: Bit k of every mask refers to unit k. An entry is feasible when some unit in its direct mask is free, or when some unit in its reconfiguration mask is free and `reconf_busy` is low.
- R5: While `reconf_busy` is high, an entry whose only free compatible units are in its reconfiguration mask is not offered.
- R6: When the head entry is infeasible, the earliest-deadline feasible entry behind it is offered, and `dsp_bypass` is high. `dsp_bypass` is low whenever the offered entry is the head.
- R7: A skipped entry stays in the list and is offered again in the first cycle in which it becomes feasible.
- R8: When no entry is feasible, `dsp_valid` is low and the stored list is left unchanged.
- R9: An entry is removed only in a cycle where `dsp_valid` and `dsp_ready` are both high. While `dsp_ready` is low and the inputs are held, the same offer is kept.
- R10: At most one entry leaves the list per cycle.
- R11: An insert into a list that holds DEPTH entries (16 by default) is dropped, and `overflow` is high in the following cycle. `overflow` is high only in that case.
- R12: `dsp_units` is the set of units the offered task may use now: its direct-mask units that are free, plus, when `reconf_busy` is low, its reconfiguration-mask units that are free.
- R13: An insert accepted at a clock edge can be offered from that edge onward. An insert and an accepted dispatch may happen in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Push a new task this cycle |
| ins_id | input | ID_W | Identifier of the pushed task |
| ins_deadline | input | DL_W | Absolute deadline of the pushed task |
| ins_direct_mask | input | N_UNITS | Units that can run the task without reprogramming |
| ins_reconf_mask | input | N_UNITS | Units that can run the task after reprogramming |
| unit_free | input | N_UNITS | Per-unit free flags |
| reconf_busy | input | 1 | Reconfiguration controller is busy |
| dsp_valid | output | 1 | A feasible task is offered |
| dsp_ready | input | 1 | The mapper takes the offered task |
| dsp_id | output | ID_W | Identifier of the offered task |
| dsp_deadline | output | DL_W | Deadline of the offered task |
| dsp_units | output | N_UNITS | Units the offered task may use now |
| dsp_bypass | output | 1 | The offered task is not the head |
| overflow | output | 1 | A push was dropped at the previous edge |

## Verification
The dispatch outputs are combinational from the stored list and the current flags, so they are due in the same cycle as the flags that cause them. The bench changes its inputs just after the falling edge and compares the outputs one time step later, before the next rising edge. An insert or a removal takes effect at the rising edge, and the overflow flag is registered at that same edge. The bench model therefore applies each handshake right after the rising edge, and its expectation for the flag is compared in the following low phase. The model is a separate sorted list, and every offer is compared against it, so retained, skipped and dropped entries show up in later offers.

// File: rtl/edf_pkg.sv
package edf_pkg;
  parameter int ID_W    = 6;
  parameter int DL_W    = 16;
  parameter int N_UNITS = 4;

  typedef struct packed {
    logic [ID_W-1:0]    id;
    logic [DL_W-1:0]    dl;
    logic [N_UNITS-1:0] dmask;
    logic [N_UNITS-1:0] rmask;
  } task_t;
endpackage

// File: rtl/edf_slot_feas.sv
module edf_slot_feas
  import edf_pkg::*;
(
  input  task_t              ent,
  input  logic               vld,
  input  logic [N_UNITS-1:0] unit_free,
  input  logic               reconf_busy,
  output logic [N_UNITS-1:0] place,
  output logic               feas
);
  logic [N_UNITS-1:0] direct_ok;
  logic [N_UNITS-1:0] reconf_ok;

  always_comb begin
    direct_ok = ent.dmask & unit_free;
    reconf_ok = reconf_busy ? '0 : (ent.rmask & unit_free);
    place     = vld ? (direct_ok | reconf_ok) : '0;
    feas      = |place;
  end
endmodule

// File: rtl/edf_first_idx.sv
module edf_first_idx #(
  parameter int N = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req[k]) begin
        found = 1'b1;
        idx   = IW'(k);
      end
    end
  end
endmodule

// File: rtl/edf_ins_pos.sv
module edf_ins_pos #(
  parameter int DEPTH = 16,
  parameter int DL_W  = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0][DL_W-1:0] dl,
  input  logic [DEPTH-1:0]           vld,
  input  logic [DL_W-1:0]            key,
  output logic [CW-1:0]              pos
);
  always_comb begin
    pos = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (vld[k] && (dl[k] <= key)) pos = pos + CW'(1);
    end
  end
endmodule

// File: rtl/edf_ready_list.sv
module edf_ready_list
  import edf_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ins_valid,
  input  logic [ID_W-1:0]    ins_id,
  input  logic [DL_W-1:0]    ins_deadline,
  input  logic [N_UNITS-1:0] ins_direct_mask,
  input  logic [N_UNITS-1:0] ins_reconf_mask,
  input  logic [N_UNITS-1:0] unit_free,
  input  logic               reconf_busy,
  output logic               dsp_valid,
  input  logic               dsp_ready,
  output logic [ID_W-1:0]    dsp_id,
  output logic [DL_W-1:0]    dsp_deadline,
  output logic [N_UNITS-1:0] dsp_units,
  output logic               dsp_bypass,
  output logic               overflow
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  task_t [DEPTH-1:0]              ent_q, rem_e, nxt_e;
  logic  [DEPTH-1:0]              vld_q, rem_v, nxt_v;
  logic  [DEPTH-1:0][N_UNITS-1:0] place;
  logic  [DEPTH-1:0]              feas;
  logic  [DEPTH-1:0][DL_W-1:0]    rem_dl;
  logic  [IW-1:0]                 sel;
  logic  [CW-1:0]                 pos;
  logic                           found, take, full, do_ins;
  task_t                          new_e;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    edf_slot_feas u_feas (
      .ent        (ent_q[g]),
      .vld        (vld_q[g]),
      .unit_free  (unit_free),
      .reconf_busy(reconf_busy),
      .place      (place[g]),
      .feas       (feas[g])
    );
  end

  edf_first_idx #(.N(DEPTH)) u_pick (
    .req  (feas),
    .found(found),
    .idx  (sel)
  );

  assign dsp_valid    = found;
  assign dsp_id       = ent_q[sel].id;
  assign dsp_deadline = ent_q[sel].dl;
  assign dsp_units    = place[sel];
  assign dsp_bypass   = found && (sel != '0);

  assign take   = found && dsp_ready;
  assign full   = vld_q[DEPTH-1];
  assign do_ins = ins_valid && !full;

  always_comb begin
    new_e.id    = ins_id;
    new_e.dl    = ins_deadline;
    new_e.dmask = ins_direct_mask;
    new_e.rmask = ins_reconf_mask;
  end

  // close the gap left by the taken entry
  always_comb begin
    for (int k = 0; k < DEPTH; k++) begin
      if (take && (k >= int'(sel))) begin
        if (k == DEPTH - 1) begin
          rem_e[k] = '0;
          rem_v[k] = 1'b0;
        end else begin
          rem_e[k] = ent_q[k+1];
          rem_v[k] = vld_q[k+1];
        end
      end else begin
        rem_e[k] = ent_q[k];
        rem_v[k] = vld_q[k];
      end
      rem_dl[k] = rem_e[k].dl;
    end
  end

  edf_ins_pos #(.DEPTH(DEPTH), .DL_W(DL_W)) u_pos (
    .dl (rem_dl),
    .vld(rem_v),
    .key(ins_deadline),
    .pos(pos)
  );

  // open a slot after every entry with a deadline not later than the new one
  always_comb begin
    for (int k = 0; k < DEPTH; k++) begin
      if (do_ins && (k > int'(pos))) begin
        nxt_e[k] = rem_e[k-1];
        nxt_v[k] = rem_v[k-1];
      end else if (do_ins && (k == int'(pos))) begin
        nxt_e[k] = new_e;
        nxt_v[k] = 1'b1;
      end else begin
        nxt_e[k] = rem_e[k];
        nxt_v[k] = rem_v[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_q    <= '0;
      vld_q    <= '0;
      overflow <= 1'b0;
    end else begin
      ent_q    <= nxt_e;
      vld_q    <= nxt_v;
      overflow <= ins_valid && full;
    end
  end
endmodule

// File: rtl/edf_list_chk.sv
module edf_list_chk
  import edf_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ins_valid,
  input logic [N_UNITS-1:0] unit_free,
  input logic               reconf_busy,
  input logic               dsp_valid,
  input logic               dsp_ready,
  input logic [ID_W-1:0]    dsp_id,
  input logic [DL_W-1:0]    dsp_deadline,
  input logic [N_UNITS-1:0] dsp_units,
  input logic               dsp_bypass,
  input logic               overflow,
  input logic [DEPTH-1:0]   vld_q
);
  // R8
  empty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_q[0] |-> !dsp_valid);

  // R11
  ovf_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && vld_q[DEPTH-1]) |=> overflow);

  // R11
  ovf_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ins_valid && vld_q[DEPTH-1]) |=> !overflow);

  // R12
  units_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_valid |-> (((dsp_units & ~unit_free) == '0) && (dsp_units != '0)));

  // R6
  bypass_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_bypass |-> dsp_valid);

  // R2
  packed_list_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((vld_q + DEPTH'(1)) & vld_q) == '0);

  // R9
  hold_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_valid && !dsp_ready && !ins_valid) |=>
      (!$stable(unit_free) || !$stable(reconf_busy) ||
       (dsp_valid && $stable(dsp_id) && $stable(dsp_deadline))));

  // R10
  one_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(vld_q) + 1 >= $past($countones(vld_q))));
endmodule

bind edf_ready_list edf_list_chk #(.DEPTH(DEPTH)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .ins_valid   (ins_valid),
  .unit_free   (unit_free),
  .reconf_busy (reconf_busy),
  .dsp_valid   (dsp_valid),
  .dsp_ready   (dsp_ready),
  .dsp_id      (dsp_id),
  .dsp_deadline(dsp_deadline),
  .dsp_units   (dsp_units),
  .dsp_bypass  (dsp_bypass),
  .overflow    (overflow),
  .vld_q       (vld_q)
);

// File: tb/edf_ready_list_tb_top.sv
module edf_ready_list_tb_top;
  import edf_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               ins_valid;
  logic [ID_W-1:0]    ins_id;
  logic [DL_W-1:0]    ins_deadline;
  logic [N_UNITS-1:0] ins_direct_mask, ins_reconf_mask, unit_free;
  logic               reconf_busy, dsp_ready;
  logic               dsp_valid, dsp_bypass, overflow;
  logic [ID_W-1:0]    dsp_id;
  logic [DL_W-1:0]    dsp_deadline;
  logic [N_UNITS-1:0] dsp_units;

  int checks = 0;
  int fails  = 0;

  // bench model of the list
  logic [ID_W-1:0]    m_id [DEPTH];
  logic [DL_W-1:0]    m_dl [DEPTH];
  logic [N_UNITS-1:0] m_dm [DEPTH];
  logic [N_UNITS-1:0] m_rm [DEPTH];
  int                 m_n = 0;
  logic               exp_ovf = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edf_ready_list #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .ins_valid(ins_valid), .ins_id(ins_id), .ins_deadline(ins_deadline),
    .ins_direct_mask(ins_direct_mask), .ins_reconf_mask(ins_reconf_mask),
    .unit_free(unit_free), .reconf_busy(reconf_busy),
    .dsp_valid(dsp_valid), .dsp_ready(dsp_ready), .dsp_id(dsp_id),
    .dsp_deadline(dsp_deadline), .dsp_units(dsp_units),
    .dsp_bypass(dsp_bypass), .overflow(overflow)
  );

  function automatic logic [N_UNITS-1:0] m_place(int k);
    return (m_dm[k] & unit_free) | (reconf_busy ? '0 : (m_rm[k] & unit_free));
  endfunction

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic drive(logic iv, int id, int dl, int dm, int rm,
                       int fr, logic bz, logic rdy);
    ins_valid       = iv;
    ins_id          = ID_W'(id);
    ins_deadline    = DL_W'(dl);
    ins_direct_mask = N_UNITS'(dm);
    ins_reconf_mask = N_UNITS'(rm);
    unit_free       = N_UNITS'(fr);
    reconf_busy     = bz;
    dsp_ready       = rdy;
  endtask

  // called just after a falling edge with the inputs already driven
  task automatic step(string tag);
    logic ev;
    int   ei, pos;
    logic full_pre;
    #1;
    ev = 1'b0;
    ei = 0;
    for (int k = 0; k < m_n; k++)
      if (!ev && (m_place(k) != '0)) begin ev = 1'b1; ei = k; end
    chk(tag, "dsp_valid", dsp_valid, ev);
    if (ev) begin
      chk(tag, "dsp_id", dsp_id, m_id[ei]);
      chk(tag, "dsp_deadline", dsp_deadline, m_dl[ei]);
      chk("R12", "dsp_units", dsp_units, m_place(ei));
      chk("R6", "dsp_bypass", dsp_bypass, ei != 0);
    end
    chk("R11", "overflow", overflow, exp_ovf);
    @(posedge clk);
    full_pre = (m_n == DEPTH);
    exp_ovf  = ins_valid && full_pre;
    if (ev && dsp_ready) begin
      for (int k = ei; k < m_n - 1; k++) begin
        m_id[k] = m_id[k+1]; m_dl[k] = m_dl[k+1];
        m_dm[k] = m_dm[k+1]; m_rm[k] = m_rm[k+1];
      end
      m_n--;
    end
    if (ins_valid && !full_pre) begin
      pos = 0;
      for (int k = 0; k < m_n; k++) if (m_dl[k] <= ins_deadline) pos = k + 1;
      for (int k = m_n; k > pos; k--) begin
        m_id[k] = m_id[k-1]; m_dl[k] = m_dl[k-1];
        m_dm[k] = m_dm[k-1]; m_rm[k] = m_rm[k-1];
      end
      m_id[pos] = ins_id; m_dl[pos] = ins_deadline;
      m_dm[pos] = ins_direct_mask; m_rm[pos] = ins_reconf_mask;
      m_n++;
    end
    @(negedge clk);
  endtask

  task automatic drain(string tag);
    for (int k = 0; k < 40 && m_n > 0; k++) begin
      drive(0, 0, 0, 0, 0, 15, 1'b0, 1'b1);
      step(tag);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive(0, 0, 0, 0, 0, 15, 1'b0, 1'b1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: empty list with every unit free offers nothing
    chk("R1", "dsp_valid", dsp_valid, 0);
    chk("R1", "overflow", overflow, 0);
    @(negedge clk);

    // R3: equal deadlines leave in arrival order; R13 insert visible next cycle
    drive(1, 1, 5, 1, 0, 0, 1'b0, 1'b0); step("R3");
    drive(1, 2, 5, 1, 0, 0, 1'b0, 1'b0); step("R3");
    drive(1, 3, 5, 1, 0, 0, 1'b0, 1'b0); step("R3");
    drive(1, 4, 2, 1, 0, 1, 1'b0, 1'b1); step("R13");
    drain("R3");

    // R5 / R4: reconfiguration-only task is held while the controller is busy
    drive(1, 9, 7, 0, 4, 15, 1'b1, 1'b1); step("R5");
    drive(0, 0, 0, 0, 0, 15, 1'b1, 1'b1); step("R5");
    drive(0, 0, 0, 0, 0, 15, 1'b1, 1'b1); step("R8");
    drive(0, 0, 0, 0, 0, 15, 1'b0, 1'b1); step("R4");

    // R6 / R7 / R9: head waits for unit 0, later task runs on unit 1
    drive(1, 10, 3, 1, 0, 0, 1'b0, 1'b0); step("R6");
    drive(1, 11, 8, 2, 0, 0, 1'b0, 1'b0); step("R6");
    drive(0, 0, 0, 0, 0, 2, 1'b0, 1'b0);  step("R9");
    drive(0, 0, 0, 0, 0, 2, 1'b0, 1'b0);  step("R9");
    drive(0, 0, 0, 0, 0, 2, 1'b0, 1'b1);  step("R6");
    drive(0, 0, 0, 0, 0, 2, 1'b0, 1'b1);  step("R8");
    drive(0, 0, 0, 0, 0, 1, 1'b0, 1'b1);  step("R7");
    drive(0, 0, 0, 0, 0, 1, 1'b0, 1'b1);  step("R1");

    // R11: fill, overflow, then drain exactly DEPTH entries
    for (int k = 0; k < DEPTH + 2; k++) begin
      drive(1, 20 + k, 100 - k, 1, 0, 0, 1'b0, 1'b1);
      step("R11");
    end
    drive(0, 0, 0, 0, 0, 0, 1'b0, 1'b1); step("R11");
    drain("R10");
    drive(0, 0, 0, 0, 0, 15, 1'b0, 1'b1); step("R11");

    // random traffic against the model
    void'($urandom(32'd1234));
    for (int c = 0; c < 4000; c++) begin
      int dm, rm;
      dm = $urandom_range(0, 15);
      rm = $urandom_range(0, 15);
      if ((dm | rm) == 0) dm = 1;
      drive(($urandom_range(0, 99) < 35), $urandom_range(0, 63),
            $urandom_range(0, 40), dm, rm, $urandom_range(0, 15),
            $urandom_range(0, 1), ($urandom_range(0, 99) < 55));
      step("R2");
    end
    drain("R2");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule